// File: doc/BRIEF.md
# UART FIFO Occupancy and DMA Handshake Controller

This block is the FIFO control path of a UART, placed between the host register port and the serial shifters. A single 8-bit control byte switches the FIFOs on or off, selects 16-entry or 64-entry usable depth, picks one of four receive trigger levels, chooses between per-character and block DMA handshaking, and carries two self-clearing strobes that flush the receive and transmit queues. Characters enter and leave each queue through one-cycle push and pop strobes. The oldest character of each queue is always visible on its read-data output.

From the two occupancy counts the block drives two active-low DMA request outputs and two interrupt requests. In per-character handshaking a request follows the empty or non-empty state of its queue. In block handshaking the receive request is raised at the trigger level and held until the queue drains, and the transmit request stays low while there is room. Reaching a trigger level never stops loading. A receive push into a full queue is dropped and latches an overrun flag.

Top module: `uart_fifo_dma_ctl`

## Requirements
- R1: After reset the queues are disabled and empty, handshaking is per-character, depth is 16, rx_count = tx_count = 0, rx_rdy_n = 1, tx_rdy_n = 0, rx_irq = 0, tx_irq = 1 and rx_overrun = 0. Control bit 4 has no effect.
- R2: Queue capacity is 1 when control bit 0 is 0. It is 16 when bit 0 is 1 and bit 5 is 0, and 64 when bits 0 and 5 are both 1. A transmit push into a full queue is dropped. Counts change one clock after a push or pop.
- R3: Each queue delivers characters in push order, and its oldest character is presented on rx_rdata or tx_rdata. A pop on an empty queue is ignored.
- R4: A receive push into a full queue (without a pop in the same cycle) leaves the contents and count unchanged and sets rx_overrun. rx_overrun stays set until the receive queue is cleared.
- R5: Writing control bit 1 clears the receive queue and rx_overrun. Writing bit 2 clears the transmit queue. A write that changes bit 0 or bit 5 clears both queues. A clear wins over a push in the same cycle, and the outputs reflect the clear one clock later.
- R6: In per-character mode (bit 3 = 0, or bit 0 = 0), rx_rdy_n is 0 exactly when the receive queue holds at least one character.
- R7: In per-character mode, tx_rdy_n is 0 exactly when the transmit queue is empty.
- R8: In block mode (bits 0 and 3 both 1), rx_rdy_n goes to 0 when the receive count reaches the trigger level and stays 0 until the count returns to 0.
- R9: In block mode, tx_rdy_n is 0 while the transmit queue is not full.
- R10: Bits 7:6 select the trigger level. In 16-entry mode codes 0, 1, 2 and 3 give 1, 4, 8 and 14 entries; in 64-entry mode they give 1, 16, 32 and 56 entries. In block mode rx_irq = (rx_count >= trigger) and tx_irq = (tx_count < trigger).
- R11: In per-character mode, rx_irq is 1 when the receive queue is non-empty, and tx_irq is 1 when the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| tx_push | input | 1 | Host loads a transmit character |
| tx_wdata | input | DW (8) | Transmit character in |
| tx_pop | input | 1 | Shifter takes a transmit character |
| tx_rdata | output | DW (8) | Oldest transmit character |
| tx_count | output | CW (7) | Transmit occupancy |
| rx_push | input | 1 | Shifter delivers a received character |
| rx_wdata | input | DW (8) | Received character in |
| rx_pop | input | 1 | Host reads a received character |
| rx_rdata | output | DW (8) | Oldest received character |
| rx_count | output | CW (7) | Receive occupancy |
| rx_overrun | output | 1 | Sticky receive overflow flag |
| tx_rdy_n | output | 1 | Active-low transmit DMA request |
| rx_rdy_n | output | 1 | Active-low receive DMA request |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_irq | output | 1 | Receive threshold interrupt |

## Verification
The hardest case to reach is the top of the 64-entry queue in block mode. To get there, 64 characters must arrive, extra pushes must hit a full queue, and the drain must then pass back below the trigger level while rx_rdy_n stays held. The bench reaches this with a sweep over every enable, handshake, depth and trigger combination. Each sweep fills the receive queue two characters past its capacity and drains it one pop past empty, comparing every output against an arithmetic model after every cycle. Separate sequences then race a clear strobe against a push and flush both queues by changing only the depth bit.

// File: rtl/uart_fifo_dma_ctl.sv
module uart_fifo_dma_ctl #(
  parameter int DW = 8,
  parameter int DEEP = 64,
  parameter int SHALLOW = 16,
  localparam int CW = $clog2(DEEP + 1),
  localparam int AW = $clog2(DEEP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  output logic [CW-1:0] tx_count,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  output logic [CW-1:0] rx_count,
  output logic          rx_overrun,
  output logic          tx_rdy_n,
  output logic          rx_rdy_n,
  output logic          tx_irq,
  output logic          rx_irq
);

  logic          fifo_en, deep_sel, blk_sel, rx_blk;
  logic [1:0]    trig_sel;
  logic [CW-1:0] cap, trig;
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [DW-1:0] tx_mem [DEEP];
  logic [DW-1:0] rx_mem [DEEP];
  logic          ctl_unused;

  assign ctl_unused = ctl_wdata[4];

  wire cfg_chg  = ctl_we && (ctl_wdata[0] != fifo_en || ctl_wdata[5] != deep_sel);
  wire rx_clr   = ctl_we && (ctl_wdata[1] || cfg_chg);
  wire tx_clr   = ctl_we && (ctl_wdata[2] || cfg_chg);
  wire blk_mode = fifo_en && blk_sel;

  assign cap = !fifo_en ? CW'(1) : deep_sel ? CW'(DEEP) : CW'(SHALLOW);

  always_comb begin
    case (trig_sel)
      2'd0:    trig = CW'(1);
      2'd1:    trig = deep_sel ? CW'(DEEP / 4) : CW'(SHALLOW / 4);
      2'd2:    trig = deep_sel ? CW'(DEEP / 2) : CW'(SHALLOW / 2);
      default: trig = deep_sel ? CW'(DEEP - 8) : CW'(SHALLOW - 2);
    endcase
  end

  wire rx_pop_ok  = rx_pop && rx_count != '0;
  wire rx_push_ok = rx_push && (rx_count != cap || rx_pop_ok);
  wire tx_pop_ok  = tx_pop && tx_count != '0;
  wire tx_push_ok = tx_push && (tx_count != cap || tx_pop_ok);

  wire [CW-1:0] rx_cnt_nx = rx_clr ? '0 : rx_count + CW'(rx_push_ok) - CW'(rx_pop_ok);
  wire [CW-1:0] tx_cnt_nx = tx_clr ? '0 : tx_count + CW'(tx_push_ok) - CW'(tx_pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en    <= 1'b0;
      deep_sel   <= 1'b0;
      blk_sel    <= 1'b0;
      trig_sel   <= 2'd0;
      rx_count   <= '0;
      tx_count   <= '0;
      rx_wp      <= '0;
      rx_rp      <= '0;
      tx_wp      <= '0;
      tx_rp      <= '0;
      rx_overrun <= 1'b0;
      rx_blk     <= 1'b0;
    end else begin
      if (ctl_we) begin
        fifo_en  <= ctl_wdata[0];
        blk_sel  <= ctl_wdata[3];
        deep_sel <= ctl_wdata[5];
        trig_sel <= ctl_wdata[7:6];
      end
      rx_count <= rx_cnt_nx;
      tx_count <= tx_cnt_nx;
      rx_blk   <= (rx_cnt_nx >= trig) || (rx_blk && rx_cnt_nx != '0);
      if (rx_clr) begin
        rx_wp      <= '0;
        rx_rp      <= '0;
        rx_overrun <= 1'b0;
      end else begin
        if (rx_push_ok) rx_wp <= rx_wp + AW'(1);
        if (rx_pop_ok)  rx_rp <= rx_rp + AW'(1);
        if (rx_push && !rx_push_ok) rx_overrun <= 1'b1;
      end
      if (tx_clr) begin
        tx_wp <= '0;
        tx_rp <= '0;
      end else begin
        if (tx_push_ok) tx_wp <= tx_wp + AW'(1);
        if (tx_pop_ok)  tx_rp <= tx_rp + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rx_push_ok && !rx_clr) rx_mem[rx_wp] <= rx_wdata;
    if (tx_push_ok && !tx_clr) tx_mem[tx_wp] <= tx_wdata;
  end

  assign rx_rdata = rx_mem[rx_rp];
  assign tx_rdata = tx_mem[tx_rp];

  assign rx_rdy_n = blk_mode ? !rx_blk : (rx_count == '0);
  assign tx_rdy_n = blk_mode ? (tx_count == cap) : (tx_count != '0);
  assign rx_irq   = blk_mode ? (rx_count >= trig) : (rx_count != '0);
  assign tx_irq   = blk_mode ? (tx_count < trig) : (tx_count == '0);

endmodule

// File: rtl/uart_fifo_dma_ctl_sva.sv
module uart_fifo_dma_ctl_sva #(
  parameter int DEEP = 64,
  parameter int SHALLOW = 16,
  localparam int CW = $clog2(DEEP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [7:0]    ctl_wdata,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          tx_push,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_rdy_n,
  input logic          tx_rdy_n,
  input logic          rx_overrun,
  input logic          fifo_en,
  input logic          deep_sel,
  input logic          blk_sel
);

  logic [CW-1:0] lim;
  assign lim = !fifo_en ? CW'(1) : deep_sel ? CW'(DEEP) : CW'(SHALLOW);
  wire blk_on = fifo_en && blk_sel;

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_count <= lim); // R2
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_count <= lim); // R2
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[1] |=> rx_count == '0 && !rx_overrun); // R5
  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[2] |=> tx_count == '0); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !ctl_we |=> rx_overrun); // R4
  AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && rx_push && !rx_pop && rx_count == lim |=> rx_overrun && rx_count == $past(rx_count)); // R4
  AST_RXRDY_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && !blk_on && rx_push |=> !rx_rdy_n); // R6
  AST_TXRDY_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && !blk_on && tx_count == '0 && tx_push |=> tx_rdy_n); // R7
  AST_RXRDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && blk_on && !rx_rdy_n && rx_count > CW'(1) |=> !rx_rdy_n); // R8

endmodule

bind uart_fifo_dma_ctl uart_fifo_dma_ctl_sva #(.DEEP(DEEP), .SHALLOW(SHALLOW)) u_sva (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push),
  .rx_count(rx_count), .tx_count(tx_count), .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n),
  .rx_overrun(rx_overrun), .fifo_en(fifo_en), .deep_sel(deep_sel), .blk_sel(blk_sel)
);

// File: tb/uart_fifo_dma_ctl_tb_top.sv
module uart_fifo_dma_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEEP = 64;
  localparam int SHALLOW = 16;
  localparam int CW = $clog2(DEEP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [DW-1:0] tx_wdata = '0, rx_wdata = '0;
  logic [DW-1:0] tx_rdata, rx_rdata;
  logic [CW-1:0] tx_count, rx_count;
  logic rx_overrun, tx_rdy_n, rx_rdy_n, tx_irq, rx_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_dma_ctl #(.DW(DW), .DEEP(DEEP), .SHALLOW(SHALLOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_count(tx_count),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_count(rx_count),
    .rx_overrun(rx_overrun), .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int m_en = 0, m_blk = 0, m_deep = 0, m_code = 0, m_ovr = 0, m_hold = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  function automatic int cap_f();
    return (m_en == 0) ? 1 : (m_deep != 0) ? DEEP : SHALLOW;
  endfunction

  function automatic int trig_f();
    if (m_code == 0) return 1;
    if (m_deep != 0) return (m_code == 3) ? 56 : 16 * m_code;
    return (m_code == 3) ? 14 : 4 * m_code;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic upd_hold();
    m_hold = (rxq.size() >= trig_f() || (m_hold != 0 && rxq.size() != 0)) ? 1 : 0;
  endtask

  task automatic check_all(string tag);
    bit bm = (m_en != 0 && m_blk != 0);
    chk({tag, " R2 rx_count"}, int'(rx_count), rxq.size());
    chk({tag, " R2 tx_count"}, int'(tx_count), txq.size());
    chk({tag, " R4 rx_overrun"}, int'(rx_overrun), m_ovr);
    if (bm) begin
      chk({tag, " R8 rx_rdy_n"}, int'(rx_rdy_n), m_hold ? 0 : 1);
      chk({tag, " R9 tx_rdy_n"}, int'(tx_rdy_n), (txq.size() == cap_f()) ? 1 : 0);
      chk({tag, " R10 rx_irq"}, int'(rx_irq), (rxq.size() >= trig_f()) ? 1 : 0);
      chk({tag, " R10 tx_irq"}, int'(tx_irq), (txq.size() < trig_f()) ? 1 : 0);
    end else begin
      chk({tag, " R6 rx_rdy_n"}, int'(rx_rdy_n), (rxq.size() == 0) ? 1 : 0);
      chk({tag, " R7 tx_rdy_n"}, int'(tx_rdy_n), (txq.size() != 0) ? 1 : 0);
      chk({tag, " R11 rx_irq"}, int'(rx_irq), (rxq.size() != 0) ? 1 : 0);
      chk({tag, " R11 tx_irq"}, int'(tx_irq), (txq.size() == 0) ? 1 : 0);
    end
    if (rxq.size() != 0) chk({tag, " R3 rx_rdata"}, int'(rx_rdata), int'(rxq[0]));
    if (txq.size() != 0) chk({tag, " R3 tx_rdata"}, int'(tx_rdata), int'(txq[0]));
  endtask

  task automatic cyc(input logic we, input logic [7:0] wd, input logic rpu, input logic [7:0] rd,
                     input logic rpo, input logic tpu, input logic [7:0] td, input logic tpo);
    @(negedge clk);
    ctl_we = we; ctl_wdata = wd;
    rx_push = rpu; rx_wdata = rd; rx_pop = rpo;
    tx_push = tpu; tx_wdata = td; tx_pop = tpo;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    ctl_we = 1'b0; rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
  endtask

  task automatic model_cfg(input logic [7:0] v);
    bit chg = (int'(v[0]) != m_en) || (int'(v[5]) != m_deep);
    if (v[1] || chg) begin rxq.delete(); m_ovr = 0; m_hold = 0; end
    if (v[2] || chg) txq.delete();
    m_en = v[0]; m_blk = v[3]; m_deep = v[5]; m_code = v[7:6];
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cyc(1'b1, v, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    model_cfg(v);
  endtask

  task automatic rx_in(input logic [7:0] d);
    cyc(1'b0, '0, 1'b1, d, 1'b0, 1'b0, '0, 1'b0);
    if (rxq.size() < cap_f()) rxq.push_back(d); else m_ovr = 1;
    upd_hold();
  endtask

  task automatic rx_out();
    cyc(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, '0, 1'b0);
    if (rxq.size() != 0) void'(rxq.pop_front());
    upd_hold();
  endtask

  task automatic tx_in(input logic [7:0] d);
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, d, 1'b0);
    if (txq.size() < cap_f()) txq.push_back(d);
  endtask

  task automatic tx_out();
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b1);
    if (txq.size() != 0) void'(txq.pop_front());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD / 4);
    rst_n = 1'b1;
    #(CLK_PERIOD);
    check_all("R1 reset");

    for (int en = 0; en < 2; en++)
      for (int dm = 0; dm < 2; dm++)
        for (int dp = 0; dp < 2; dp++)
          for (int code = 0; code < 4; code++) begin
            logic [7:0] v;
            int c;
            v = {2'(code), 1'(dp), 1'(code), 1'(dm), 1'b1, 1'b1, 1'(en)};
            wr_cfg(v);
            check_all("R1 R5 cfg");
            c = cap_f();
            for (int i = 0; i < c + 2; i++) begin
              rx_in(8'(i * 7 + 3));
              check_all("R2 R4 R8 rx fill");
            end
            for (int i = 0; i < c + 1; i++) begin
              rx_out();
              check_all("R3 R8 rx drain");
            end
            wr_cfg({2'(code), 1'(dp), 1'b0, 1'(dm), 1'b0, 1'b1, 1'(en)});
            check_all("R4 R5 rx clear");
            for (int i = 0; i < c + 1; i++) begin
              tx_in(8'(i * 5 + 11));
              check_all("R2 R9 R10 tx fill");
            end
            for (int i = 0; i < c + 1; i++) begin
              tx_out();
              check_all("R3 R7 tx drain");
            end
          end

    wr_cfg(8'h07);
    for (int i = 0; i < 3; i++) rx_in(8'(i + 40));
    check_all("R5 pre-race");
    cyc(1'b1, 8'h03, 1'b1, 8'hEE, 1'b0, 1'b0, '0, 1'b0);
    model_cfg(8'h03);
    check_all("R5 clear beats push");
    rx_in(8'hA5);
    check_all("R5 R3 pointer restart");

    for (int i = 0; i < 2; i++) begin
      rx_in(8'(i + 90));
      tx_in(8'(i + 70));
    end
    check_all("R5 pre-depth");
    wr_cfg(8'h21);
    check_all("R5 depth change flush");
    chk("R5 depth flush rx_count", int'(rx_count), 0);
    chk("R5 depth flush tx_count", int'(tx_count), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule